// File: doc/BRIEF.md
# Register-Driven Endpoint Test Engine

This block is a self-test function placed on the target side of a bus endpoint. Software reaches it through a small word-addressed register window. It can write a probe value into a pattern register and read it back. It sets up source and destination addresses, a word count and an interrupt selection. It then starts work by writing a command word. The engine serves one command at a time and sets busy while it works. When it finishes, it records success or failure in a status register and raises an interrupt request that carries a type and a vector.

Three kinds of work are supported:
- Pulling a block of words from a simple memory port into a local buffer.
- Pushing the local buffer out to the memory port.
- Copying a block inside the memory port word by word, with a running checksum over the words read and the words written.

A fourth kind only raises an interrupt. Address, length and vector checks stop bad requests before they touch memory or the interrupt output.

Top module: `ep_test_engine`

## Requirements
- R1: After reset every register reads zero. The pattern register (word index 0) returns exactly the last value written to it.
- R2: The register window uses these word indices: 0 pattern, 1 command, 2 status, 3 source address, 4 destination address, 5 word count (16 bits), 6 interrupt type (2 bits), 7 interrupt number (12 bits). Command bits 0, 1 and 2 each raise one interrupt with type 0 (legacy), 1 (MSI) or 2 (MSI-X), and the vector equals the interrupt number register.
- R3: Command bit 3 reads `count` words from the source address into the local buffer. Status bit 0 is set on success and bit 1 on failure.
- R4: Command bit 4 writes `count` buffered words to the destination address. Status bit 2 is set on success and bit 3 on failure.
- R5: Command bit 5 copies `count` words from source to destination, one read and then one write per word. The sum of the words read is compared with the sum of the words written. Status bit 4 is set on success and bit 5 on failure (a mismatch or a memory error).
- R6: An address is invalid if it is not a multiple of 4, or if address + 4*count exceeds the memory size. An invalid source sets status bit 7 and an invalid destination sets bit 8, each together with the command's fail bit. The memory port is then never accessed.
- R7: A read or write command with a count above the buffer depth sets its fail bit and makes no memory access.
- R8: A memory error response ends the operation at once with the fail bit set. No further words are accessed.
- R9: Every read, write or copy ends with an interrupt of the type held in the type register. Each interrupt request is a single-cycle pulse, and status bit 6 is set whenever one is issued.
- R10: An interrupt number outside the range allowed for its type suppresses the pulse, and status bit 6 stays clear. The allowed ranges are 0 for legacy, 1 to 32 for MSI and 1 to 2048 for MSI-X; type 3 is never allowed.
- R11: When several command bits are set, only the lowest one is served. The whole command register clears on acceptance. Command writes made while busy are dropped.
- R12: Writing 1 to a status bit clears it. Status bit 9 shows busy and cannot be written.
- R13: The memory request stays high with a stable address and direction until it is acknowledged. Each word costs exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_type | output | 2 | Interrupt type: 0 legacy, 1 MSI, 2 MSI-X |
| irq_vec | output | 12 | Interrupt vector |
| busy | output | 1 | Command in progress |

## Verification
The bound checker watches several properties on every cycle:
- Interrupt pulses are one cycle long and never leave their vector range.
- Memory requests and interrupts appear only while busy.
- Every access is word-aligned and inside the memory.
- A pending request holds its address and direction until acknowledged.
- A pattern write is visible on the next read.

Only the directed scenarios can show the rest: the status codes for each outcome, the data that lands in memory, the access count per word, lowest-bit selection, commands dropped while busy, the write-1-to-clear behaviour, and an early stop on an error response.

// File: rtl/ept_pkg.sv
package ept_pkg;
  localparam logic [2:0] RA_PAT  = 3'd0;
  localparam logic [2:0] RA_CMD  = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_SRC  = 3'd3;
  localparam logic [2:0] RA_DST  = 3'd4;
  localparam logic [2:0] RA_LEN  = 3'd5;
  localparam logic [2:0] RA_TYPE = 3'd6;
  localparam logic [2:0] RA_NUM  = 3'd7;

  localparam int ST_RD_OK   = 0;
  localparam int ST_RD_BAD  = 1;
  localparam int ST_WR_OK   = 2;
  localparam int ST_WR_BAD  = 3;
  localparam int ST_CP_OK   = 4;
  localparam int ST_CP_BAD  = 5;
  localparam int ST_RAISED  = 6;
  localparam int ST_SRC_BAD = 7;
  localparam int ST_DST_BAD = 8;
  localparam int ST_W       = 9;
  localparam int CMD_W      = 6;
  localparam int NUM_W      = 12;

  typedef enum logic [1:0] {OP_RAISE, OP_READ, OP_WRITE, OP_COPY} op_t;

  // Vector range allowed for each interrupt kind.
  function automatic logic vec_ok(input logic [1:0] kind, input logic [NUM_W-1:0] num);
    case (kind)
      2'd0:    return num == '0;
      2'd1:    return (num != '0) && (num <= NUM_W'(32));
      2'd2:    return (num != '0) && (num <= NUM_W'(2048));
      default: return 1'b0;
    endcase
  endfunction

  // Aligned start and the whole block inside the memory.
  function automatic logic span_ok(input logic [31:0] addr, input logic [15:0] words,
                                   input logic [32:0] limit);
    logic [33:0] end_a;
    end_a = {2'b00, addr} + {16'b0, words, 2'b00};
    return (addr[1:0] == 2'b00) && (end_a <= {1'b0, limit});
  endfunction

  // Index of the lowest set command bit.
  function automatic logic [2:0] lowest_set(input logic [CMD_W-1:0] cmd);
    logic [2:0] r;
    r = '0;
    for (int i = CMD_W - 1; i >= 0; i--)
      if (cmd[i]) r = 3'(i);
    return r;
  endfunction
endpackage

// File: rtl/ep_cmd_regs.sv
module ep_cmd_regs
  import ept_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 busy,
  input  logic                 accept,
  input  logic [ST_W-1:0]      stat_set,
  input  logic                 raised_ev,
  output logic [CMD_W-1:0]     cmd_q,
  output logic [31:0]          src_q,
  output logic [31:0]          dst_q,
  output logic [LEN_W-1:0]     len_q,
  output logic [1:0]           type_q,
  output logic [NUM_W-1:0]     num_q
);
  logic [31:0]     pat_q;
  logic [ST_W-1:0] stat_q;
  logic [ST_W-1:0] clr_mask;
  logic [ST_W-1:0] set_mask;

  always_comb begin
    clr_mask = (reg_we && reg_addr == RA_STAT) ? reg_wdata[ST_W-1:0] : '0;
    set_mask = stat_set;
    set_mask[ST_RAISED] = stat_set[ST_RAISED] | raised_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q  <= '0;
      cmd_q  <= '0;
      stat_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      type_q <= '0;
      num_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | set_mask;
      if (accept)
        cmd_q <= '0;
      else if (reg_we && reg_addr == RA_CMD && !busy)
        cmd_q <= reg_wdata[CMD_W-1:0];
      if (reg_we) begin
        case (reg_addr)
          RA_PAT:  pat_q  <= reg_wdata;
          RA_SRC:  src_q  <= reg_wdata;
          RA_DST:  dst_q  <= reg_wdata;
          RA_LEN:  len_q  <= reg_wdata[LEN_W-1:0];
          RA_TYPE: type_q <= reg_wdata[1:0];
          RA_NUM:  num_q  <= reg_wdata[NUM_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_PAT:  reg_rdata = pat_q;
      RA_CMD:  reg_rdata = 32'(cmd_q);
      RA_STAT: reg_rdata = 32'({busy, stat_q});
      RA_SRC:  reg_rdata = src_q;
      RA_DST:  reg_rdata = dst_q;
      RA_LEN:  reg_rdata = 32'(len_q);
      RA_TYPE: reg_rdata = 32'(type_q);
      default: reg_rdata = 32'(num_q);
    endcase
  end
endmodule

// File: rtl/ep_xfer_seq.sv
module ep_xfer_seq
  import ept_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int MEM_BYTES = 1024,
  parameter int LEN_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [31:0]        src,
  input  logic [31:0]        dst,
  input  logic [LEN_W-1:0]   len,
  input  logic [1:0]         type_reg,
  output logic               accept,
  output logic               busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_err,
  output logic               irq_go,
  output logic [1:0]         irq_kind,
  output logic [ST_W-1:0]    stat_set
);
  localparam int BUF_AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} state_t;

  state_t           st_q;
  op_t              op_q;
  logic [1:0]       kind_q;
  logic [LEN_W-1:0] idx_q;
  logic             fail_q, inv_s_q, inv_d_q;
  logic [31:0]      sum_rd_q, sum_wr_q, hold_q;
  logic [31:0]      buf_q [BUF_DEPTH];

  logic [2:0] pick;
  logic       src_ok, dst_ok, too_long, last, zero_len;

  always_comb begin
    pick     = lowest_set(cmd);
    src_ok   = span_ok(src, 16'(len), 33'(MEM_BYTES));
    dst_ok   = span_ok(dst, 16'(len), 33'(MEM_BYTES));
    too_long = len > LEN_W'(BUF_DEPTH);
    zero_len = len == '0;
    last     = idx_q == (len - 1'b1);
  end

  assign accept    = (st_q == S_IDLE) && (cmd != '0);
  assign busy      = st_q != S_IDLE;
  assign mem_req   = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = st_q == S_WR;
  assign mem_addr  = ((st_q == S_WR) ? dst : src) + (32'(idx_q) << 2);
  assign mem_wdata = (op_q == OP_COPY) ? hold_q : buf_q[idx_q[BUF_AW-1:0]];
  assign irq_go    = st_q == S_FIN;
  assign irq_kind  = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; op_q <= OP_RAISE; kind_q <= '0; idx_q <= '0;
      fail_q <= 1'b0; inv_s_q <= 1'b0; inv_d_q <= 1'b0;
      sum_rd_q <= '0; sum_wr_q <= '0; hold_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          idx_q <= '0; sum_rd_q <= '0; sum_wr_q <= '0;
          fail_q <= 1'b0; inv_s_q <= 1'b0; inv_d_q <= 1'b0;
          kind_q <= type_reg;
          case (pick)
            3'd3: begin
              op_q <= OP_READ;
              if (!src_ok || too_long) begin
                inv_s_q <= !src_ok; fail_q <= 1'b1; st_q <= S_FIN;
              end else st_q <= zero_len ? S_FIN : S_RD;
            end
            3'd4: begin
              op_q <= OP_WRITE;
              if (!dst_ok || too_long) begin
                inv_d_q <= !dst_ok; fail_q <= 1'b1; st_q <= S_FIN;
              end else st_q <= zero_len ? S_FIN : S_WR;
            end
            3'd5: begin
              op_q <= OP_COPY;
              if (!src_ok || !dst_ok) begin
                inv_s_q <= !src_ok; inv_d_q <= !dst_ok; fail_q <= 1'b1; st_q <= S_FIN;
              end else st_q <= zero_len ? S_FIN : S_RD;
            end
            default: begin
              op_q <= OP_RAISE; kind_q <= pick[1:0]; st_q <= S_FIN;
            end
          endcase
        end
        S_RD: if (mem_ack) begin
          if (mem_err) begin
            fail_q <= 1'b1; st_q <= S_FIN;
          end else begin
            sum_rd_q <= sum_rd_q + mem_rdata;
            if (op_q == OP_COPY) begin
              hold_q <= mem_rdata; st_q <= S_WR;
            end else begin
              idx_q <= idx_q + 1'b1;
              if (last) st_q <= S_FIN;
            end
          end
        end
        S_WR: if (mem_ack) begin
          if (mem_err) begin
            fail_q <= 1'b1; st_q <= S_FIN;
          end else begin
            sum_wr_q <= sum_wr_q + mem_wdata;
            idx_q    <= idx_q + 1'b1;
            if (last) begin
              st_q <= S_FIN;
              if (op_q == OP_COPY && sum_rd_q != sum_wr_q + mem_wdata) fail_q <= 1'b1;
            end else begin
              st_q <= (op_q == OP_COPY) ? S_RD : S_WR;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_RD && mem_ack && !mem_err && op_q == OP_READ)
      buf_q[idx_q[BUF_AW-1:0]] <= mem_rdata;
  end

  always_comb begin
    stat_set = '0;
    if (st_q == S_FIN) begin
      case (op_q)
        OP_READ:  stat_set[fail_q ? ST_RD_BAD : ST_RD_OK] = 1'b1;
        OP_WRITE: stat_set[fail_q ? ST_WR_BAD : ST_WR_OK] = 1'b1;
        OP_COPY:  stat_set[fail_q ? ST_CP_BAD : ST_CP_OK] = 1'b1;
        default:  ;
      endcase
      stat_set[ST_SRC_BAD] = inv_s_q;
      stat_set[ST_DST_BAD] = inv_d_q;
    end
  end
endmodule

// File: rtl/ep_irq_gen.sv
module ep_irq_gen
  import ept_pkg::*;
(
  input  logic             irq_go,
  input  logic [1:0]       kind,
  input  logic [NUM_W-1:0] num,
  output logic             irq_valid,
  output logic [1:0]       irq_type,
  output logic [NUM_W-1:0] irq_vec,
  output logic             raised_ev
);
  logic in_range;
  assign in_range  = vec_ok(kind, num);
  assign irq_valid = irq_go && in_range;
  assign raised_ev = irq_valid;
  assign irq_type  = kind;
  assign irq_vec   = num;
endmodule

// File: rtl/ep_test_engine.sv
module ep_test_engine
  import ept_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int BUF_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        irq_valid,
  output logic [1:0]  irq_type,
  output logic [11:0] irq_vec,
  output logic        busy
);
  localparam int LEN_W = 16;

  logic [CMD_W-1:0] cmd_q;
  logic [31:0]      src_q, dst_q;
  logic [LEN_W-1:0] len_q;
  logic [1:0]       type_q, irq_kind;
  logic [NUM_W-1:0] num_q;
  logic             accept, irq_go, raised_ev;
  logic [ST_W-1:0]  stat_set;

  ep_cmd_regs #(.LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .accept(accept),
    .stat_set(stat_set), .raised_ev(raised_ev), .cmd_q(cmd_q), .src_q(src_q),
    .dst_q(dst_q), .len_q(len_q), .type_q(type_q), .num_q(num_q)
  );

  ep_xfer_seq #(.BUF_DEPTH(BUF_DEPTH), .MEM_BYTES(MEM_BYTES), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .src(src_q), .dst(dst_q), .len(len_q),
    .type_reg(type_q), .accept(accept), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err), .irq_go(irq_go), .irq_kind(irq_kind),
    .stat_set(stat_set)
  );

  ep_irq_gen u_irq (
    .irq_go(irq_go), .kind(irq_kind), .num(num_q), .irq_valid(irq_valid),
    .irq_type(irq_type), .irq_vec(irq_vec), .raised_ev(raised_ev)
  );
endmodule

// File: rtl/ept_chk.sv
module ept_chk #(
  parameter int MEM_BYTES = 1024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        irq_valid,
  input logic [1:0]  irq_type,
  input logic [11:0] irq_vec,
  input logic        busy
);
  p_pattern_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0) |=>
      (reg_we || reg_addr != 3'd0 || reg_rdata == $past(reg_wdata)));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  p_vec_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((irq_type == 2'd0 && irq_vec == 12'd0) ||
                   (irq_type == 2'd1 && irq_vec >= 12'd1 && irq_vec <= 12'd32) ||
                   (irq_type == 2'd2 && irq_vec >= 12'd1 && irq_vec <= 12'd2048)));

  p_irq_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> busy);

  p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00 && mem_addr < 32'(MEM_BYTES)));

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind ep_test_engine ept_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .irq_valid(irq_valid), .irq_type(irq_type), .irq_vec(irq_vec), .busy(busy)
);

// File: tb/sim_ep_test_engine.sv
`timescale 1ns/1ps
module sim_ep_test_engine;
  localparam int MEMB = 1024;
  localparam logic [2:0] A_PAT = 0, A_CMD = 1, A_STAT = 2, A_SRC = 3,
                         A_DST = 4, A_LEN = 5, A_TYPE = 6, A_NUM = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_err = 1'b0;
  logic        irq_valid, busy;
  logic [1:0]  irq_type;
  logic [11:0] irq_vec;

  logic [31:0] mem [MEMB/4];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int errors = 0, checks = 0;
  int irq_cnt = 0, acc_cnt = 0;
  logic [1:0]  last_type = '0;
  logic [11:0] last_vec = '0;

  always #10 clk = ~clk;

  ep_test_engine #(.MEM_BYTES(MEMB), .BUF_DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .irq_valid(irq_valid), .irq_type(irq_type), .irq_vec(irq_vec), .busy(busy)
  );

  // Memory model: acknowledges one cycle after a new request.
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        acc_cnt   = acc_cnt + 1;
        mem_rdata <= mem[mem_addr[9:2]];
        mem_err   <= (mem_addr == err_addr);
        if (mem_we && mem_addr != err_addr) mem[mem_addr[9:2]] <= mem_wdata;
      end
    end
  end

  always @(negedge clk) if (rst_n && irq_valid) begin
    irq_cnt   = irq_cnt + 1;
    last_type = irq_type;
    last_vec  = irq_vec;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_cmd(input logic [31:0] c);
    wr(A_CMD, c);
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic expect_stat(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(A_STAT, v);
    check(tag, v, exp);
    wr(A_STAT, 32'h1FF);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check("R1 reset register zero", v, 0);
    end
    check("R1 reset busy low", {31'b0, busy}, 0);
  endtask

  task automatic t_pattern;
    logic [31:0] v;
    wr(A_PAT, 32'hA5C3_0F96); rd(A_PAT, v);
    check("R1 pattern readback", v, 32'hA5C3_0F96);
    wr(A_PAT, 32'h0000_0001); rd(A_PAT, v);
    check("R1 pattern second value", v, 32'h1);
    wr(A_SRC, 32'h1234); rd(A_SRC, v);
    check("R2 source register index 3", v, 32'h1234);
  endtask

  task automatic t_raise;
    int n0;
    logic [31:0] v;
    n0 = irq_cnt;
    wr(A_NUM, 0); run_cmd(32'h1);
    check("R2 legacy pulse count", irq_cnt - n0, 1);
    check("R2 legacy type", {30'b0, last_type}, 0);
    check("R2 legacy vector", {20'b0, last_vec}, 0);
    rd(A_STAT, v);
    check("R9 raised bit after pulse", v, 32'h40);
    wr(A_STAT, 32'h240); rd(A_STAT, v);
    check("R12 write-1 clears, busy bit not writable", v, 0);
    wr(A_NUM, 5); run_cmd(32'h2);
    check("R2 MSI type", {30'b0, last_type}, 1);
    check("R2 MSI vector", {20'b0, last_vec}, 5);
    expect_stat("R9 MSI raised", 32'h40);
    wr(A_NUM, 2048); run_cmd(32'h4);
    check("R2 MSI-X type", {30'b0, last_type}, 2);
    check("R2 MSI-X top vector", {20'b0, last_vec}, 2048);
    expect_stat("R9 MSI-X raised", 32'h40);
  endtask

  task automatic t_vec_range;
    int n0;
    n0 = irq_cnt;
    wr(A_NUM, 0);    run_cmd(32'h2);
    expect_stat("R10 MSI vector 0 suppressed", 0);
    wr(A_NUM, 33);   run_cmd(32'h2);
    expect_stat("R10 MSI vector 33 suppressed", 0);
    wr(A_NUM, 2049); run_cmd(32'h4);
    expect_stat("R10 MSI-X vector 2049 suppressed", 0);
    wr(A_NUM, 3);    run_cmd(32'h1);
    expect_stat("R10 legacy vector 3 suppressed", 0);
    check("R10 no pulses for bad vectors", irq_cnt - n0, 0);
    wr(A_NUM, 32);   run_cmd(32'h2);
    check("R10 MSI vector 32 allowed", irq_cnt - n0, 1);
    expect_stat("R10 MSI 32 raised", 32'h40);
  endtask

  task automatic t_read_write;
    int a0, n0;
    for (int i = 0; i < 4; i++) mem[16 + i] <= 32'hC0DE_0000 + 32'(i * 7);
    wr(A_TYPE, 1); wr(A_NUM, 7);
    wr(A_SRC, 32'h40); wr(A_LEN, 4);
    a0 = acc_cnt; n0 = irq_cnt;
    run_cmd(32'h8);
    expect_stat("R3 read success", 32'h41);
    check("R3 read accesses", acc_cnt - a0, 4);
    check("R9 completion type from register", {30'b0, last_type}, 1);
    check("R9 completion vector", {20'b0, last_vec}, 7);
    check("R9 one completion pulse", irq_cnt - n0, 1);
    wr(A_DST, 32'h100); a0 = acc_cnt;
    run_cmd(32'h10);
    expect_stat("R4 write success", 32'h44);
    check("R4 write accesses", acc_cnt - a0, 4);
    for (int i = 0; i < 4; i++)
      check("R4 written word", mem[64 + i], 32'hC0DE_0000 + 32'(i * 7));
    wr(A_DST, 32'h3F0);
    run_cmd(32'h10);
    expect_stat("R6 block ending at memory top is valid", 32'h44);
    check("R4 last word at top", mem[255], 32'hC0DE_0015);
  endtask

  task automatic t_copy;
    int a0;
    for (int i = 0; i < 8; i++) begin
      mem[128 + i] <= 32'h1111_0000 ^ 32'(i * 313);
      mem[192 + i] <= 32'hDEAD_BEEF;
    end
    wr(A_SRC, 32'h200); wr(A_DST, 32'h300); wr(A_LEN, 8);
    a0 = acc_cnt;
    run_cmd(32'h20);
    expect_stat("R5 copy success", 32'h50);
    check("R13 one access per word", acc_cnt - a0, 16);
    for (int i = 0; i < 8; i++)
      check("R5 copied word", mem[192 + i], 32'h1111_0000 ^ 32'(i * 313));
  endtask

  task automatic t_invalid;
    int a0;
    a0 = acc_cnt;
    wr(A_SRC, 32'h42); wr(A_LEN, 2);
    run_cmd(32'h8);
    expect_stat("R6 misaligned source", 32'hC2);
    wr(A_DST, 32'h3FC);
    run_cmd(32'h10);
    expect_stat("R6 destination past end", 32'h148);
    wr(A_SRC, 32'h401); wr(A_DST, 32'h402);
    run_cmd(32'h20);
    expect_stat("R6 both copy addresses bad", 32'h1E0);
    check("R6 no memory access", acc_cnt - a0, 0);
    wr(A_SRC, 0); wr(A_DST, 0); wr(A_LEN, 17);
    run_cmd(32'h8);
    expect_stat("R7 read longer than buffer", 32'h42);
    run_cmd(32'h10);
    expect_stat("R7 write longer than buffer", 32'h48);
    check("R7 no memory access", acc_cnt - a0, 0);
  endtask

  task automatic t_err;
    int a0;
    for (int i = 0; i < 4; i++) mem[192 + i] <= 32'h5A5A_5A5A;
    wr(A_SRC, 32'h200); wr(A_DST, 32'h300); wr(A_LEN, 4);
    err_addr = 32'h208;
    a0 = acc_cnt;
    run_cmd(32'h20);
    err_addr = 32'hFFFF_FFFF;
    expect_stat("R8 copy fail on error response", 32'h60);
    check("R8 stops after failing read", acc_cnt - a0, 5);
    check("R8 word after error untouched", mem[194], 32'h5A5A_5A5A);
  endtask

  task automatic t_prio_busy;
    int a0, n0;
    logic [31:0] v;
    wr(A_SRC, 32'h40); wr(A_DST, 32'h80); wr(A_LEN, 2);
    a0 = acc_cnt;
    run_cmd(32'h18);
    expect_stat("R11 lowest bit (read) served", 32'h41);
    check("R11 only the read accesses", acc_cnt - a0, 2);
    rd(A_CMD, v);
    check("R11 command register cleared", v, 0);
    wr(A_SRC, 32'h200); wr(A_DST, 32'h300); wr(A_LEN, 8);
    n0 = irq_cnt;
    wr(A_CMD, 32'h20);
    repeat (4) @(negedge clk);
    check("R11 busy during copy", {31'b0, busy}, 1);
    wr(A_CMD, 32'h1);
    rd(A_CMD, v);
    check("R11 command write dropped while busy", v, 0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11 only the copy interrupt", irq_cnt - n0, 1);
    expect_stat("R11 copy status only", 32'h50);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMB/4; i++) mem[i] <= 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pattern();
    t_raise();
    t_vec_range();
    t_read_write();
    t_copy();
    t_invalid();
    t_err();
    t_prio_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule